// File: doc/BRIEF.md
# Interrupt Mask and Priority Resolver

This block sits between a CPU's sequencer and the interrupt sources of a microcontroller. It collects three non-maskable requests and fifteen maskable ones. It applies the global mask bits that it holds, picks a single winner, and presents that winner's vector index together with a valid flag. The sequencer answers with a one-cycle `take_i` pulse when it starts servicing the vector that is shown. On that pulse the block sets the maskable-group mask bit, and it clears the latched edge request of the external maskable pin.

Software changes the two mask bits through set, clear and condition-code write strobes. The condition-code write also serves the return-from-interrupt restore. A 4-bit promotion register lifts one maskable source above all other maskable sources. The external maskable pin senses either an active-low level or a falling edge. The choice between the two can be written only during a short window after reset. Each peripheral's request arrives together with its own enable bit. The block combines the two, and that is all it does for the peripherals.

Top module: `irq_resolver`

## Requirements
- R1: The group mask bit `i_mask` is 1 after reset. `sei_i` sets it, `cli_i` clears it, and `ccr_wr_i` loads it from `ccr_i_i`; the priority order is `ccr_wr_i`, then `sei_i`, then `cli_i`. While `i_mask` is 1, no maskable vector (index 3 or higher) is presented.
- R2: The pin mask bit `x_mask` is 1 after reset. `ccr_wr_i` with `ccr_x_i`=0 clears it. Writing 1 has no effect, so once cleared it stays 0 until the next reset. While `x_mask` is 1, the pin `nmi_n_i` is not presented.
- R3: A take (`take_i` high while `irq_valid` is high) of a vector of 3 or higher sets `i_mask` in the next cycle. This overrides every software write made in the same cycle.
- R4: The non-maskable vectors have a fixed order: 0 = `nmi_n_i` low with `x_mask` 0, then 1 = `illop_i`, then 2 = `swi_i`. Vectors 1 and 2 are presented whatever the mask bits hold. All three rank above every maskable source.
- R5: The maskable vectors are 3 for the external pin and 3+k for `per_req_i[k-1] & per_en_i[k-1]` (k = 1..14). When no source is promoted, the lowest vector index wins.
- R6: The promotion register reads 0 after reset and is loaded by `prio_wr_i` from `prio_val_i`. A value p below 15 makes maskable vector 3+p beat every other maskable source. A value of 15 promotes nothing.
- R7: In level mode, which is the reset default (`edge_mode`=0), the external pin requests vector 3 in every cycle in which `ext_n_i` is low.
- R8: In edge mode, `ext_n_i` sampled high at one clock and low at the next sets a pending flag that requests vector 3 from the following cycle on. A take of vector 3 clears the flag unless a new falling edge arrives in the same cycle. Leaving edge mode drops the flag.
- R9: `opt_wr_i` loads `edge_mode` from `opt_edge_i` only at the first 64 rising clock edges that see `rst_n` high after reset. Later writes leave `edge_mode` unchanged.
- R10: `irq_valid` is 1 exactly when some source is eligible, and `irq_vec` then carries the winner's index. When `irq_valid` is 0, `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n_i | input | 1 | Non-maskable external pin, active low level |
| illop_i | input | 1 | Illegal-opcode trap request |
| swi_i | input | 1 | Software interrupt request |
| ext_n_i | input | 1 | Maskable external pin, active low |
| per_req_i | input | 14 | Peripheral request flags |
| per_en_i | input | 14 | Peripheral enable bits |
| take_i | input | 1 | Sequencer accepts the presented vector |
| sei_i | input | 1 | Set group mask |
| cli_i | input | 1 | Clear group mask |
| ccr_wr_i | input | 1 | Condition-code write (transfer or return restore) |
| ccr_x_i | input | 1 | Value written to the pin mask (only 0 acts) |
| ccr_i_i | input | 1 | Value written to the group mask |
| prio_wr_i | input | 1 | Promotion register write strobe |
| prio_val_i | input | 4 | Promotion register write value |
| opt_wr_i | input | 1 | Edge-select write strobe |
| opt_edge_i | input | 1 | Edge-select value (1 = falling edge) |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 5 | Winner's vector index |
| i_mask | output | 1 | Group mask bit |
| x_mask | output | 1 | Pin mask bit |
| edge_mode | output | 1 | External pin senses falling edges |

## Verification
The assertions assume that every input is a clean synchronous level that is stable around the rising edge. They also assume that the sequencer raises `take_i` without regard to `irq_valid`, which is harmless because a take is counted only while `irq_valid` is high. The stimulus changes inputs only between clock edges. It uses sparse random requests, mask writes and promotion writes, and it pulses reset now and then so that the edge-select window opens again. Both the writes that fall inside the window and the writes that fall after it are exercised.

// File: rtl/irq_res_pkg.sv
// Package: fixed vector numbering shared by the resolver modules.
// Assumes three non-maskable sources occupy the lowest vector indices.
package irq_res_pkg;
    localparam int NMI_COUNT = 3;
    localparam int VEC_PIN   = 0;
    localparam int VEC_TRAP  = 1;
    localparam int VEC_SOFT  = 2;
    localparam int VEC_MASK0 = 3;
endpackage

// File: rtl/irq_mask_regs.sv
// Mask and option registers: group mask (I), one-way pin mask (X),
// promotion select and the edge-select bit with its post-reset write window.
// Assumes synchronous active-low reset and single-cycle strobes.
module irq_mask_regs #(
    parameter int WINDOW = 64,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sei_i,
    input  logic              cli_i,
    input  logic              ccr_wr_i,
    input  logic              ccr_x_i,
    input  logic              ccr_i_i,
    input  logic              take_mask_i,
    input  logic              prio_wr_i,
    input  logic [PSEL_W-1:0] prio_val_i,
    input  logic              opt_wr_i,
    input  logic              opt_edge_i,
    output logic              i_mask_o,
    output logic              x_mask_o,
    output logic [PSEL_W-1:0] prio_sel_o,
    output logic              edge_mode_o
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    logic [CNT_W-1:0] win_cnt_q;
    logic             win_open;

    assign win_open = (win_cnt_q < CNT_W'(WINDOW));

    // Group mask: a take wins, then condition-code write, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           i_mask_o <= 1'b1;
        else if (take_mask_i) i_mask_o <= 1'b1;
        else if (ccr_wr_i)    i_mask_o <= ccr_i_i;
        else if (sei_i)       i_mask_o <= 1'b1;
        else if (cli_i)       i_mask_o <= 1'b0;
    end

    // Pin mask: only a written zero has any effect.
    always_ff @(posedge clk) begin
        if (!rst_n)                    x_mask_o <= 1'b1;
        else if (ccr_wr_i && !ccr_x_i) x_mask_o <= 1'b0;
    end

    // Promotion select register.
    always_ff @(posedge clk) begin
        if (!rst_n)         prio_sel_o <= '0;
        else if (prio_wr_i) prio_sel_o <= prio_val_i;
    end

    // Window counter saturating at WINDOW.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_cnt_q <= '0;
        else if (win_open) win_cnt_q <= win_cnt_q + 1'b1;
    end

    // Edge select: writable only while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)                    edge_mode_o <= 1'b0;
        else if (opt_wr_i && win_open) edge_mode_o <= opt_edge_i;
    end

    p_x_oneway_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(x_mask_o));

    p_take_sets_i_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_mask_i |=> i_mask_o);

    p_edge_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt_q == CNT_W'(WINDOW)) |=> $stable(edge_mode_o));
endmodule

// File: rtl/irq_ext_sense.sv
// External maskable pin sensing: active-low level or latched falling edge.
// Assumes the pin is already synchronous to clk.
module irq_ext_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic take_ext_i,
    output logic req_o
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall  = prev_q && !pin_n_i;
    assign req_o = edge_mode_i ? pend_q : !pin_n_i;

    // Previous pin sample, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_n_i;
    end

    // Pending flag: a new edge beats a take in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= edge_mode_i && (fall || (pend_q && !take_ext_i));
    end

    p_edge_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && prev_q && !pin_n_i) |=> pend_q);
endmodule

// File: rtl/irq_pick.sv
// Winner selection: fixed non-maskable order, then an optional promoted
// maskable source, then the lowest maskable index. Purely combinational.
module irq_pick
    import irq_res_pkg::*;
#(
    parameter int NM     = 15,
    parameter int PSEL_W = 4,
    parameter int VEC_W  = 5
) (
    input  logic              pin_i,
    input  logic              trap_i,
    input  logic              soft_i,
    input  logic [NM-1:0]     mreq_i,
    input  logic              i_mask_i,
    input  logic [PSEL_W-1:0] prio_sel_i,
    output logic              valid_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic [NM-1:0]    eff;
    logic             promo_hit;
    logic             fix_hit;
    logic [VEC_W-1:0] fix_vec;
    logic [VEC_W-1:0] promo_vec;

    assign eff = i_mask_i ? '0 : mreq_i;

    // Promoted source lookup.
    always_comb begin
        promo_hit = 1'b0;
        promo_vec = '0;
        for (int k = 0; k < NM; k++) begin
            if (int'(prio_sel_i) == k && eff[k]) begin
                promo_hit = 1'b1;
                promo_vec = VEC_W'(VEC_MASK0 + k);
            end
        end
    end

    // Lowest-index maskable request.
    always_comb begin
        fix_hit = 1'b0;
        fix_vec = '0;
        for (int k = NM - 1; k >= 0; k--) begin
            if (eff[k]) begin
                fix_hit = 1'b1;
                fix_vec = VEC_W'(VEC_MASK0 + k);
            end
        end
    end

    // Final ranking.
    always_comb begin
        valid_o = 1'b1;
        if (pin_i)          vec_o = VEC_W'(VEC_PIN);
        else if (trap_i)    vec_o = VEC_W'(VEC_TRAP);
        else if (soft_i)    vec_o = VEC_W'(VEC_SOFT);
        else if (promo_hit) vec_o = promo_vec;
        else if (fix_hit)   vec_o = fix_vec;
        else begin
            valid_o = 1'b0;
            vec_o   = '0;
        end
    end
endmodule

// File: rtl/irq_resolver.sv
// Top: interrupt mask and priority resolver. Combines peripheral requests
// with their enables, senses the external pin, applies masks and presents
// one vector. Assumes take_i is a single-cycle pulse from the sequencer.
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter int N_PER  = 14,
    parameter int WINDOW = 64,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_n_i,
    input  logic              illop_i,
    input  logic              swi_i,
    input  logic              ext_n_i,
    input  logic [N_PER-1:0]  per_req_i,
    input  logic [N_PER-1:0]  per_en_i,
    input  logic              take_i,
    input  logic              sei_i,
    input  logic              cli_i,
    input  logic              ccr_wr_i,
    input  logic              ccr_x_i,
    input  logic              ccr_i_i,
    input  logic              prio_wr_i,
    input  logic [PSEL_W-1:0] prio_val_i,
    input  logic              opt_wr_i,
    input  logic              opt_edge_i,
    output logic              irq_valid,
    output logic [$clog2(NMI_COUNT+N_PER+1)-1:0] irq_vec,
    output logic              i_mask,
    output logic              x_mask,
    output logic              edge_mode
);
    localparam int NM    = N_PER + 1;
    localparam int VEC_W = $clog2(NMI_COUNT + NM);

    logic [NM-1:0]     mreq;
    logic              ext_req;
    logic              pin_act;
    logic              take;
    logic              take_mask;
    logic              take_ext;
    logic [PSEL_W-1:0] prio_sel;

    assign pin_act   = !nmi_n_i && !x_mask;
    assign take      = take_i && irq_valid;
    assign take_mask = take && (irq_vec >= VEC_W'(VEC_MASK0));
    assign take_ext  = take && (irq_vec == VEC_W'(VEC_MASK0));
    assign mreq[0]   = ext_req;

    // Peripheral request qualification by enable bit.
    for (genvar g = 0; g < N_PER; g++) begin : g_per
        assign mreq[g+1] = per_req_i[g] && per_en_i[g];
    end

    irq_mask_regs #(.WINDOW(WINDOW), .PSEL_W(PSEL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sei_i       (sei_i),
        .cli_i       (cli_i),
        .ccr_wr_i    (ccr_wr_i),
        .ccr_x_i     (ccr_x_i),
        .ccr_i_i     (ccr_i_i),
        .take_mask_i (take_mask),
        .prio_wr_i   (prio_wr_i),
        .prio_val_i  (prio_val_i),
        .opt_wr_i    (opt_wr_i),
        .opt_edge_i  (opt_edge_i),
        .i_mask_o    (i_mask),
        .x_mask_o    (x_mask),
        .prio_sel_o  (prio_sel),
        .edge_mode_o (edge_mode)
    );

    irq_ext_sense u_ext (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n_i     (ext_n_i),
        .edge_mode_i (edge_mode),
        .take_ext_i  (take_ext),
        .req_o       (ext_req)
    );

    irq_pick #(.NM(NM), .PSEL_W(PSEL_W), .VEC_W(VEC_W)) u_pick (
        .pin_i      (pin_act),
        .trap_i     (illop_i),
        .soft_i     (swi_i),
        .mreq_i     (mreq),
        .i_mask_i   (i_mask),
        .prio_sel_i (prio_sel),
        .valid_o    (irq_valid),
        .vec_o      (irq_vec)
    );

    p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && i_mask) |-> (irq_vec < VEC_W'(VEC_MASK0)));

    p_trap_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (illop_i && (nmi_n_i || x_mask)) |-> (irq_valid && irq_vec == VEC_W'(VEC_TRAP)));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vec == '0));
endmodule

// File: tb/tb_irq_resolver.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the outputs at every falling edge.
module tb_irq_resolver;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_n_i, illop_i, swi_i, ext_n_i;
    logic [13:0] per_req_i, per_en_i;
    logic        take_i, sei_i, cli_i, ccr_wr_i, ccr_x_i, ccr_i_i;
    logic        prio_wr_i, opt_wr_i, opt_edge_i;
    logic [3:0]  prio_val_i;
    logic        irq_valid, i_mask, x_mask, edge_mode;
    logic [4:0]  irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit armed = 0;

    // Reference state.
    bit mi, mx, medge, mpend, mprev;
    int mpsel, mcnt;

    always #5 clk = ~clk;

    irq_resolver dut (
        .clk(clk), .rst_n(rst_n), .nmi_n_i(nmi_n_i), .illop_i(illop_i),
        .swi_i(swi_i), .ext_n_i(ext_n_i), .per_req_i(per_req_i),
        .per_en_i(per_en_i), .take_i(take_i), .sei_i(sei_i), .cli_i(cli_i),
        .ccr_wr_i(ccr_wr_i), .ccr_x_i(ccr_x_i), .ccr_i_i(ccr_i_i),
        .prio_wr_i(prio_wr_i), .prio_val_i(prio_val_i), .opt_wr_i(opt_wr_i),
        .opt_edge_i(opt_edge_i), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .i_mask(i_mask), .x_mask(x_mask), .edge_mode(edge_mode)
    );

    function automatic int model_pick();
        bit req [15];
        if (!nmi_n_i && !mx) return 0;
        if (illop_i) return 1;
        if (swi_i) return 2;
        if (mi) return -1;
        req[0] = medge ? mpend : !ext_n_i;
        for (int k = 1; k < 15; k++) req[k] = per_req_i[k-1] && per_en_i[k-1];
        if (mpsel < 15 && req[mpsel]) return 3 + mpsel;
        for (int k = 0; k < 15; k++) if (req[k]) return 3 + k;
        return -1;
    endfunction

    // Reference update at each rising edge.
    always @(posedge clk) begin
        int  w;
        bit  fall, npend;
        if (!rst_n) begin
            mi = 1; mx = 1; medge = 0; mpend = 0; mprev = 1; mpsel = 0; mcnt = 0;
        end else begin
            w     = model_pick();
            fall  = mprev && !ext_n_i;
            npend = medge && (fall || (mpend && !(take_i && w == 3)));
            if (take_i && w >= 3) mi = 1;
            else if (ccr_wr_i)    mi = ccr_i_i;
            else if (sei_i)       mi = 1;
            else if (cli_i)       mi = 0;
            if (ccr_wr_i && !ccr_x_i) mx = 0;
            if (prio_wr_i) mpsel = int'(prio_val_i);
            if (opt_wr_i && mcnt < 64) medge = opt_edge_i;
            if (mcnt < 64) mcnt++;
            mprev = ext_n_i;
            mpend = npend;
        end
        armed = 1;
    end

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        int w = model_pick();
        chk("R10 R4 R5 R7 R8 valid", int'(irq_valid), (w >= 0) ? 1 : 0);
        chk("R4 R5 R6 R7 R8 R10 vector", int'(irq_vec), (w >= 0) ? w : 0);
        chk("R1 R3 group mask", int'(i_mask), int'(mi));
        chk("R2 pin mask", int'(x_mask), int'(mx));
        chk("R9 edge select", int'(edge_mode), int'(medge));
    endtask

    task automatic idle();
        nmi_n_i = 1; illop_i = 0; swi_i = 0; ext_n_i = 1;
        per_req_i = '0; per_en_i = '0; take_i = 0; sei_i = 0; cli_i = 0;
        ccr_wr_i = 0; ccr_x_i = 1; ccr_i_i = 1; prio_wr_i = 0; prio_val_i = '0;
        opt_wr_i = 0; opt_edge_i = 0;
    endtask

    task automatic cycle();
        @(negedge clk);
        if (armed) compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) cycle();
        // Reset state: R1 R2 R9 R10
        chk("R1 reset group mask", int'(i_mask), 1);
        chk("R2 reset pin mask", int'(x_mask), 1);
        chk("R9 reset edge select", int'(edge_mode), 0);
        chk("R10 reset idle", int'(irq_valid), 0);
        rst_n = 1;
        // R4: software interrupt presented despite the group mask.
        swi_i = 1; cycle();
        chk("R4 soft vector", int'(irq_vec), 2);
        idle();
        // R2: clear pin mask, then try to set it again.
        ccr_wr_i = 1; ccr_x_i = 0; ccr_i_i = 1; cycle();
        ccr_x_i = 1; cycle();
        idle(); cycle();
        chk("R2 set attempt ignored", int'(x_mask), 0);
        // R9: wait out the window, then write edge mode.
        repeat (70) cycle();
        opt_wr_i = 1; opt_edge_i = 1; cycle();
        idle(); cycle();
        chk("R9 late write ignored", int'(edge_mode), 0);
        // R6 R7: level request with promotion of peripheral 5 (vector 8).
        cli_i = 1; cycle();
        cli_i = 0; prio_wr_i = 1; prio_val_i = 4'd5; cycle();
        prio_wr_i = 0; ext_n_i = 0; per_req_i = 14'h0010; per_en_i = 14'h0010; cycle();
        chk("R6 promoted vector", int'(irq_vec), 8);
        // R3: take sets the group mask.
        take_i = 1; cycle();
        idle(); cycle();
        chk("R3 take sets mask", int'(i_mask), 1);
        // Random phase with periodic resets.
        for (int it = 0; it < 6000; it++) begin
            if (it % 900 == 0) begin
                idle(); rst_n = 0; cycle(); cycle(); rst_n = 1;
            end
            nmi_n_i    = ($urandom_range(0, 9) != 0);
            illop_i    = ($urandom_range(0, 29) == 0);
            swi_i      = ($urandom_range(0, 29) == 0);
            if ($urandom_range(0, 3) == 0) ext_n_i = ~ext_n_i;
            per_req_i  = 14'($urandom & $urandom & $urandom);
            per_en_i   = 14'($urandom);
            take_i     = $urandom_range(0, 1) == 1;
            sei_i      = ($urandom_range(0, 14) == 0);
            cli_i      = ($urandom_range(0, 5) == 0);
            ccr_wr_i   = ($urandom_range(0, 19) == 0);
            ccr_x_i    = ($urandom_range(0, 3) != 0);
            ccr_i_i    = $urandom_range(0, 1) == 1;
            prio_wr_i  = ($urandom_range(0, 19) == 0);
            prio_val_i = 4'($urandom_range(0, 15));
            opt_wr_i   = ($urandom_range(0, 7) == 0);
            opt_edge_i = ($urandom_range(0, 9) < 7);
            cycle();
        end
        finish_run();
    end
endmodule